// File: doc/BRIEF.md
# Bidirectional Parallel Port Bank

This block holds a bank of byte-wide general-purpose I/O ports behind a simple processor I/O bus. Each port owns a data register and a direction register. Every bit can be set on its own to drive its pin or to sample it. Software reaches the six registers through chip select, read and write strobes. Only the low byte of the bus address is decoded, so the bank answers in every 256-byte page of I/O space.

The last port is special. Its two top bits never drive a pin. On reads they return the synchronized levels of two interrupt request pins: the higher request on the top bit, the lower request on the bit below it. Writing a one to either bit sends a one-cycle clear pulse to the matching edge-detect latch in the interrupt controller, which lies outside this block.

Every port except the first has a select input. While a port is deselected it never drives its pins, but its registers still work as scratch storage. A bit whose direction is output reads back its latched data. A bit whose direction is input reads its pin. A value written while a bit is an input is kept, and it shows up once that bit is switched to output.

Top module: `pport_bank`

## Requirements
- R1: After reset every direction bit reads 1, every data bit is 0, and no pin is driven (`pin_oe` and `pin_out` are all zero).
- R2: Only `bus_addr[7:0]` is decoded. Port k (0 = A, 1 = B, 2 = C) has its data register at `REG_BASE + 2k` and its direction register at `REG_BASE + 2k + 1`, with `REG_BASE` defaulting to 0xE0. A read of any other low byte returns 0.
- R3: A register write takes effect on the rising clock edge while `bus_cs` and `bus_wr` are both high. A direction bit of 0 makes the bit an output: on a selected port its `pin_oe` bit is 1 and its `pin_out` bit equals the data bit, and `pin_out` is 0 wherever `pin_oe` is 0.
- R4: Reading a data register returns the data bit for each output bit and the pin level for each input bit. Pin levels pass through two flops, so a pin change is first seen in a read after the second rising edge.
- R5: Bits 7 and 6 of port C are never driven. Whatever their direction bits hold, they read as the synchronized `irq_pin[1]` (bit 7) and `irq_pin[0]` (bit 6).
- R6: Writing port C data with bit 7 or bit 6 set makes `irq_edge_clr[1]` or `irq_edge_clr[0]` high for exactly the one cycle after the write edge. Zero bits, and writes to any other register, give no pulse.
- R7: `port_sel[0]` selects port B and `port_sel[1]` selects port C bits 5 to 0. A deselected port drives no pin, and its registers stay readable and writable.
- R8: In a deselected port, output bits read back the latched data and input bits read the pin. Data written to an input bit is latched and becomes readable once that bit's direction is set to 0.
- R9: `bus_rdata` is 0 unless `bus_cs` and `bus_rd` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs | input | 1 | Chip select for the register bank |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | BUS_AW | I/O address; only the low byte is decoded |
| bus_wdata | input | PORT_W | Write data |
| bus_rdata | output | PORT_W | Read data, combinational |
| port_sel | input | NUM_PORTS-1 | Select for ports B onward, one bit each |
| pin_in | input | NUM_PORTS*PORT_W | Pin levels, port A in the low byte |
| pin_out | output | NUM_PORTS*PORT_W | Pin drive values |
| pin_oe | output | NUM_PORTS*PORT_W | Pin output enables |
| irq_pin | input | 2 | Interrupt request pin levels |
| irq_edge_clr | output | 2 | Edge-detect clear pulses |

## Verification
The bench builds the block with its defaults: three byte-wide ports, a 16-bit bus address and a register base of 0xE0. At that size the input-only pair and the select-dependent scratch behaviour both fall on port C. Varying upper address bytes show that the page is ignored. The full register window sits next to unmapped low bytes on both sides, so the decode edges can be reached.

// File: rtl/pport_pkg.sv
package pport_pkg;

    localparam int unsigned IRQ_N = 2;

    typedef enum logic [0:0] {
        REG_DATA = 1'b0,
        REG_DIR  = 1'b1
    } reg_kind_e;

    typedef struct packed {
        logic      hit;
        logic [7:0] port;
        reg_kind_e kind;
    } dec_t;

    typedef struct packed {
        logic data_we;
        logic dir_we;
    } port_we_t;

    // Decode the low address byte against a base; two registers per port.
    function automatic dec_t decode_low(input logic [7:0] low,
                                        input logic [7:0] base,
                                        input int unsigned nports);
        logic [7:0] off;
        dec_t d;
        off    = low - base;
        d.hit  = (32'(off) < 2 * nports);
        d.port = {1'b0, off[7:1]};
        d.kind = reg_kind_e'(off[0]);
        return d;
    endfunction

endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d_async;
            stage2 <= stage1;
        end
    end

    assign q_sync = stage2;
endmodule

// File: rtl/pport_cell.sv
module pport_cell
    import pport_pkg::*;
#(
    parameter int unsigned     W        = 8,
    parameter logic [W-1:0]    IN_ONLY  = '0,
    parameter logic [W-1:0]    SEL_BITS = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  port_we_t     we,
    input  logic [W-1:0] wdata,
    input  logic         sel,
    input  logic [W-1:0] pin_sync,
    output logic [W-1:0] rd_data,
    output logic [W-1:0] rd_dir,
    output logic [W-1:0] drv_val,
    output logic [W-1:0] drv_en
);
    logic [W-1:0] data_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] dir_eff;
    logic [W-1:0] sel_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            dir_q  <= '1;
        end else begin
            if (we.data_we) data_q <= wdata;
            if (we.dir_we)  dir_q  <= wdata;
        end
    end

    // Input-only bits behave as inputs whatever their direction bit says.
    assign dir_eff  = dir_q | IN_ONLY;
    assign sel_mask = sel ? {W{1'b1}} : ~SEL_BITS;

    assign drv_en  = ~dir_eff & sel_mask;
    assign drv_val = data_q & drv_en;
    assign rd_data = (data_q & ~dir_eff) | (pin_sync & dir_eff);
    assign rd_dir  = dir_q;
endmodule

// File: rtl/pport_irqclr.sv
module pport_irqclr
    import pport_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hit_we,
    input  logic [IRQ_N-1:0] wbits,
    output logic [IRQ_N-1:0] clr
);
    always_ff @(posedge clk) begin
        if (rst) clr <= '0;
        else     clr <= hit_we ? wbits : '0;
    end
endmodule

// File: rtl/pport_bank.sv
module pport_bank
    import pport_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 3,
    parameter int unsigned PORT_W    = 8,
    parameter int unsigned BUS_AW    = 16,
    parameter logic [7:0]  REG_BASE  = 8'hE0
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bus_cs,
    input  logic                        bus_wr,
    input  logic                        bus_rd,
    input  logic [BUS_AW-1:0]           bus_addr,
    input  logic [PORT_W-1:0]           bus_wdata,
    output logic [PORT_W-1:0]           bus_rdata,
    input  logic [NUM_PORTS-2:0]        port_sel,
    input  logic [NUM_PORTS*PORT_W-1:0] pin_in,
    output logic [NUM_PORTS*PORT_W-1:0] pin_out,
    output logic [NUM_PORTS*PORT_W-1:0] pin_oe,
    input  logic [IRQ_N-1:0]            irq_pin,
    output logic [IRQ_N-1:0]            irq_edge_clr
);
    localparam int unsigned PIN_W = NUM_PORTS * PORT_W;
    localparam int unsigned LAST  = NUM_PORTS - 1;
    localparam logic [PORT_W-1:0] TOP_IN_ONLY = ~({PORT_W{1'b1}} >> IRQ_N);

    dec_t dec;
    logic wr_go;
    logic rd_go;
    logic [PIN_W-1:0]  pin_s;
    logic [IRQ_N-1:0]  irq_s;
    logic [PORT_W-1:0] rd_data_a [NUM_PORTS];
    logic [PORT_W-1:0] rd_dir_a  [NUM_PORTS];

    assign dec   = decode_low(bus_addr[7:0], REG_BASE, NUM_PORTS);
    assign wr_go = bus_cs & bus_wr & dec.hit;
    assign rd_go = bus_cs & bus_rd & dec.hit;

    pport_sync #(.W(PIN_W)) u_pin_sync (
        .clk(clk), .rst(rst), .d_async(pin_in), .q_sync(pin_s)
    );

    pport_sync #(.W(IRQ_N)) u_irq_sync (
        .clk(clk), .rst(rst), .d_async(irq_pin), .q_sync(irq_s)
    );

    for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
        port_we_t          we;
        logic              sel;
        logic [PORT_W-1:0] view;

        assign we.data_we = wr_go && (dec.port == 8'(k)) && (dec.kind == REG_DATA);
        assign we.dir_we  = wr_go && (dec.port == 8'(k)) && (dec.kind == REG_DIR);

        if (k == 0) begin : g_fixed
            assign sel = 1'b1;
        end else begin : g_selectable
            assign sel = port_sel[k-1];
        end

        if (k == LAST) begin : g_top
            assign view = {irq_s, pin_s[k*PORT_W +: PORT_W-IRQ_N]};
            pport_cell #(
                .W(PORT_W), .IN_ONLY(TOP_IN_ONLY), .SEL_BITS({PORT_W{1'b1}})
            ) u_cell (
                .clk(clk), .rst(rst), .we(we), .wdata(bus_wdata), .sel(sel),
                .pin_sync(view), .rd_data(rd_data_a[k]), .rd_dir(rd_dir_a[k]),
                .drv_val(pin_out[k*PORT_W +: PORT_W]),
                .drv_en(pin_oe[k*PORT_W +: PORT_W])
            );
        end else begin : g_plain
            assign view = pin_s[k*PORT_W +: PORT_W];
            pport_cell #(
                .W(PORT_W), .IN_ONLY({PORT_W{1'b0}}), .SEL_BITS({PORT_W{1'b1}})
            ) u_cell (
                .clk(clk), .rst(rst), .we(we), .wdata(bus_wdata), .sel(sel),
                .pin_sync(view), .rd_data(rd_data_a[k]), .rd_dir(rd_dir_a[k]),
                .drv_val(pin_out[k*PORT_W +: PORT_W]),
                .drv_en(pin_oe[k*PORT_W +: PORT_W])
            );
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_go) begin
            for (int k = 0; k < NUM_PORTS; k++) begin
                if (dec.port == 8'(k)) begin
                    bus_rdata = (dec.kind == REG_DIR) ? rd_dir_a[k] : rd_data_a[k];
                end
            end
        end
    end

    pport_irqclr u_irqclr (
        .clk(clk),
        .rst(rst),
        .hit_we(wr_go && (dec.port == 8'(LAST)) && (dec.kind == REG_DATA)),
        .wbits(bus_wdata[PORT_W-1 -: IRQ_N]),
        .clr(irq_edge_clr)
    );
endmodule

// File: rtl/pport_bank_chk.sv
module pport_bank_chk
    import pport_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 3,
    parameter int unsigned PORT_W    = 8,
    parameter int unsigned BUS_AW    = 16,
    parameter logic [7:0]  REG_BASE  = 8'hE0
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        bus_cs,
    input logic                        bus_wr,
    input logic                        bus_rd,
    input logic [BUS_AW-1:0]           bus_addr,
    input logic [PORT_W-1:0]           bus_wdata,
    input logic [PORT_W-1:0]           bus_rdata,
    input logic [NUM_PORTS-2:0]        port_sel,
    input logic [NUM_PORTS*PORT_W-1:0] pin_out,
    input logic [NUM_PORTS*PORT_W-1:0] pin_oe,
    input logic [IRQ_N-1:0]            irq_edge_clr
);
    localparam int unsigned PIN_W  = NUM_PORTS * PORT_W;
    localparam logic [7:0]  C_DATA = REG_BASE + 8'(2 * (NUM_PORTS - 1));

    // R1: reset leaves every pin undriven
    p_reset_inputs_r1: assert property (@(posedge clk) rst |=> (pin_oe == '0));

    // R3: a pin value only appears where the pin is enabled
    p_out_needs_en_r3: assert property (@(posedge clk) disable iff (rst)
        ((pin_out & ~pin_oe) == '0));

    // R5: the interrupt monitor bits are never driven
    p_irq_undriven_r5: assert property (@(posedge clk) disable iff (rst)
        (pin_oe[PIN_W-1 -: IRQ_N] == '0));

    // R6: clear pulse follows a top-port data write
    p_clr_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_cs && bus_wr && bus_addr[7:0] == C_DATA)
        |=> (irq_edge_clr == $past(bus_wdata[PORT_W-1 -: IRQ_N])));

    // R6: no pulse without a write
    p_clr_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !(bus_cs && bus_wr) |=> (irq_edge_clr == '0));

    // R7: a deselected port drives nothing
    for (genvar k = 1; k < NUM_PORTS; k++) begin : g_desel
        p_desel_quiet_r7: assert property (@(posedge clk) disable iff (rst)
            !port_sel[k-1] |-> (pin_oe[k*PORT_W +: PORT_W] == '0));
    end

    // R9: read bus idles at zero
    p_rd_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !(bus_cs && bus_rd) |-> (bus_rdata == '0));
endmodule

bind pport_bank pport_bank_chk #(
    .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .BUS_AW(BUS_AW), .REG_BASE(REG_BASE)
) u_chk (
    .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .port_sel(port_sel), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_edge_clr(irq_edge_clr)
);

// File: tb/pport_bank_test.sv
module pport_bank_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_cs = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [1:0]  port_sel = 2'b11;
    logic [23:0] pin_in = 24'h3CC35A;
    logic [23:0] pin_out;
    logic [23:0] pin_oe;
    logic [1:0]  irq_pin = 2'b10;
    logic [1:0]  irq_edge_clr;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pport_bank uut (
        .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .port_sel(port_sel), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .irq_pin(irq_pin), .irq_edge_clr(irq_edge_clr)
    );

    // {is_write, addr, wdata, expected read}
    localparam logic [32:0] VEC [12] = '{
        {1'b0, 16'h00E1, 8'h00, 8'hFF},   // R1 dir A resets to inputs
        {1'b0, 16'h12E0, 8'h00, 8'h5A},   // R4 all inputs read pins
        {1'b1, 16'h34E1, 8'h0F, 8'h00},   // R3 A high nibble output
        {1'b1, 16'h00E0, 8'h37, 8'h00},
        {1'b0, 16'hFFE0, 8'h00, 8'h3A},   // R4 mixed, R2 page ignored
        {1'b0, 16'h00E4, 8'h00, 8'hBC},   // R5 C top bits from irq pins
        {1'b1, 16'h00E5, 8'h00, 8'h00},
        {1'b1, 16'hA0E4, 8'hFF, 8'h00},
        {1'b0, 16'h00E4, 8'h00, 8'hBF},   // R5 top bits stay irq
        {1'b0, 16'h00E5, 8'h00, 8'h00},   // R3 dir stored
        {1'b0, 16'h00E6, 8'h00, 8'h00},   // R2 unmapped above
        {1'b0, 16'h00DF, 8'h00, 8'h00}    // R2 unmapped below
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_cs = 1'b0; bus_wr = 1'b0;
        #1;
    endtask

    task automatic bus_read(input logic [15:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_cs = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #1;
        check(tag, 32'(bus_rdata), 32'(exp));
        bus_cs = 1'b0; bus_rd = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 pin_oe after reset", 32'(pin_oe), 32'h0);
        check("R1 pin_out after reset", 32'(pin_out), 32'h0);
        check("R1 irq_edge_clr after reset", 32'(irq_edge_clr), 32'h0);

        for (int i = 0; i < 12; i++) begin
            if (VEC[i][32]) bus_write(VEC[i][31:16], VEC[i][15:8]);
            else bus_read(VEC[i][31:16], VEC[i][7:0], $sformatf("R2/R4 vector %0d", i));
        end

        check("R3 pin_oe after writes", 32'(pin_oe), 32'h3F00F0);
        check("R3 pin_out after writes", 32'(pin_out), 32'h3F0030);

        // R6 clear pulses
        bus_write(16'h00E4, 8'h80);
        check("R6 pulse int2", 32'(irq_edge_clr), 32'h2);
        @(negedge clk); #1;
        check("R6 pulse one cycle", 32'(irq_edge_clr), 32'h0);
        bus_write(16'h00E4, 8'h7F);
        check("R6 pulse int1", 32'(irq_edge_clr), 32'h1);
        bus_write(16'h00E4, 8'h3F);
        check("R6 zero bits no pulse", 32'(irq_edge_clr), 32'h0);
        bus_write(16'h00E0, 8'hF7);
        check("R6 other register no pulse", 32'(irq_edge_clr), 32'h0);
        bus_write(16'h00E0, 8'h37);

        // R4 two-flop latency
        @(negedge clk);
        pin_in[7:0] = 8'hA5;
        bus_read(16'h00E0, 8'h3A, "R4 one edge old value");
        bus_read(16'h00E0, 8'h35, "R4 two edges new value");

        // R5 irq level change
        irq_pin = 2'b01;
        repeat (3) @(negedge clk);
        bus_read(16'h00E4, 8'h7F, "R5 irq pins on bits 7:6");
        bus_write(16'h00E5, 8'h00);
        check("R5 top bits undriven", 32'(pin_oe[23:22]), 32'h0);

        // R7 / R8 deselected port C
        @(negedge clk);
        port_sel = 2'b01;
        #1;
        check("R7 C deselected oe", 32'(pin_oe), 32'h0000F0);
        check("R7 C deselected out", 32'(pin_out), 32'h000030);
        bus_read(16'h00E4, 8'h7F, "R8 deselected output bits latched");
        bus_write(16'h00E5, 8'h0F);
        bus_write(16'h00E4, 8'h15);
        bus_read(16'h00E4, 8'h5C, "R8 deselected input bits read pins");
        bus_write(16'h00E5, 8'h00);
        bus_read(16'h00E4, 8'h55, "R8 latched value revealed");
        check("R7 still undriven", 32'(pin_oe[23:16]), 32'h0);

        // R7 port B
        @(negedge clk);
        port_sel = 2'b00;
        bus_write(16'h00E3, 8'h00);
        check("R7 B deselected no drive", 32'(pin_oe[15:8]), 32'h0);
        bus_read(16'h00E3, 8'h00, "R7 B dir writable");
        @(negedge clk);
        port_sel = 2'b01;
        #1;
        check("R7 B reselected drives", 32'(pin_oe[15:8]), 32'hFF);
        check("R7 B reselected value", 32'(pin_out[15:8]), 32'h00);

        // R9 read strobes
        @(negedge clk);
        bus_cs = 1'b1; bus_rd = 1'b0; bus_addr = 16'h00E1;
        #1;
        check("R9 no rd strobe", 32'(bus_rdata), 32'h0);
        bus_cs = 1'b0; bus_rd = 1'b1;
        #1;
        check("R9 no chip select", 32'(bus_rdata), 32'h0);
        bus_rd = 1'b0;

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule